// File: doc/BRIEF.md
# Write-Once Watchdog Timer with Gated Reset Request

This block is a watchdog timer that sits on a plain memory-mapped write/read bus. One control register carries a 12-bit reload value, a prescaler select, an arming enable and a 2-bit mode field. The first write to that register stores the whole configuration and freezes it until the next system reset. Software is expected to program the mode field to 2 when it arms the timer. From then on every write to the same address, whatever data it carries, serves only as a keepalive that restarts the count. The count clock runs at half the bus clock rate, made here as a clock enable. With the prescaler selected, that rate is divided further by a parameterised factor, 16384 by default.

When the count runs out, the block raises a level interrupt that stays high until the next keepalive. It also makes a one-cycle reset request, but only when the reset-enable register permits it. That small register, at its own offset, holds a master enable in bit 0 and one enable per watchdog instance in the bits above it. Bit 1 serves instance 0 and bit 2 serves instance 1. The instance index is a parameter.

Top module: `wdt_top`

## Requirements
- R1: After reset, irq and rst_req are low, and reads of the control register (offset 0x000) and the reset-enable register (offset 0x120) both return 0.
- R2: The first write to offset 0x000 stores reload = wdata[11:0], prescaler select = wdata[12], enable = wdata[13] and mode = wdata[15:14]. Reads of that offset then return this configuration in bits 15:0, with bit 16 set to 1 as a "written" status and all other bits 0.
- R3: A write to offset 0x000 after the first write leaves the value read back from that offset unchanged.
- R4: With enable set and prescaler select clear, the counter steps once every 2 bus clock cycles. irq rises 2*(reload+1) cycles after the clock edge that takes the arming write; this holds for reload 0 and for reload 4095.
- R5: With the prescaler selected, the counter steps once every 2*PRESC_DIV cycles. irq rises 2*PRESC_DIV*(reload+1) cycles after the arming edge.
- R6: Once the timer is armed, a write to offset 0x000 with any data clears irq on the edge that takes it and restarts the whole timing from that edge, as if the timer had just been armed.
- R7: On expiry the counter reloads itself and keeps counting. irq stays high through later expiries, and each later expiry comes 2*(reload+1) cycles (non-prescaled) after the one before.
- R8: On each expiry, rst_req is high for exactly one cycle, starting at the same edge that raises or holds irq. This happens only if reset-enable bit 0 and bit 1+WDT_IDX are both 1; otherwise rst_req stays low.
- R9: If the first write to offset 0x000 has enable (bit 13) clear, the timer stays disarmed until reset: irq and rst_req stay low, and later writes have no effect.
- R10: A write to offset 0x120 stores wdata[N_WDT:0]; reads return those bits, with all higher bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the count clock is half its rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register offset for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Expiry interrupt; level, cleared by a keepalive write |
| rst_req | output | 1 | One-cycle reset request on expiry, gated by the reset-enable register |

## Verification
The hardest situations to reach are the ones the write-once lock rules out. One is a timer locked in the disarmed state. Another is a later write that would rearm the timer or change its reload. Each of these can only happen once per reset. The stimulus therefore resets the block between scenarios. In one scenario the first write has its enable bit clear; in another the block is armed and then written again with different data. The scoreboard expects the exact edge of every interrupt rise and reset pulse, so an event that should not happen is caught as an event nobody expected. The gating cases change the reset-enable bits while an armed timer keeps expiring on its own.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Control register field layout (decoded by software, so positions are fixed)
  localparam int RLD_W     = 12;
  localparam int MODE_W    = 2;
  localparam int PRESC_BIT = RLD_W;
  localparam int EN_BIT    = RLD_W + 1;
  localparam int CFG_W     = RLD_W + 2 + MODE_W;
  localparam int STAT_BIT  = CFG_W;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              en;
    logic              presc;
    logic [RLD_W-1:0]  reload;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output wdt_cfg_t         cfg,
  output logic             written,
  output logic             armed,
  output logic             load
);
  wdt_cfg_t cfg_q, cfg_d;
  logic     wrt_q, wrt_d;

  always_comb begin
    cfg_d = cfg_q;
    wrt_d = wrt_q;
    if (wr && !wrt_q) begin
      cfg_d = wdt_cfg_t'(wdata);
      wrt_d = 1'b1;
    end
  end

  // Arming write (enable set) or keepalive on an armed timer
  assign load    = wr && (wrt_q ? cfg_q.en : wdata[EN_BIT]);
  assign cfg     = cfg_q;
  assign written = wrt_q;
  assign armed   = wrt_q && cfg_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wrt_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      wrt_q <= wrt_d;
    end
  end
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int PRESC_DIV = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic presc,
  output logic tick
);
  localparam int PC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic half_q, half_d;
  logic wclk_en;

  always_comb begin
    if (restart || !run) half_d = 1'b0;
    else                 half_d = ~half_q;
  end

  assign wclk_en = run && half_q && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  generate
    if (PRESC_DIV > 1) begin : g_div
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESC_DIV - 1);
      logic [PC_W-1:0] pc_q, pc_d;

      always_comb begin
        pc_d = pc_q;
        if (restart || !run)       pc_d = '0;
        else if (presc && wclk_en) pc_d = (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
      end

      assign tick = wclk_en && (!presc || (pc_q == PC_LAST));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end
    end else begin : g_nodiv
      logic unused_presc;
      assign unused_presc = presc;
      assign tick = wclk_en;
    end
  endgenerate
endmodule

// File: rtl/wdt_down.sv
module wdt_down
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RLD_W-1:0] reload,
  input  logic             tick,
  output logic             expire
);
  logic [RLD_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick && !load && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = reload;
    else if (tick)    cnt_d = at_zero ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_rsten.sv
module wdt_rsten #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);
  logic [W-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr) en_d = wdata;
  end

  assign en = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFF  = 'h000,
  parameter logic [ADDR_W-1:0] RSTEN_OFF = 'h120,
  parameter int                PRESC_DIV = 16384,
  parameter int                N_WDT     = 2,
  parameter int                WDT_IDX   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int RSTEN_W = N_WDT + 1;

  logic [1:0]         sync_q;
  logic               rst_ni;
  logic               wr_ctrl, wr_rsten;
  wdt_cfg_t           cfg_q;
  logic               written, armed, load, tick, expire;
  logic [RSTEN_W-1:0] rsten_q;
  logic               irq_q, irq_d, rreq_q, rreq_d;
  logic               unused_wdata;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_ni = sync_q[1];

  assign wr_ctrl      = bus_wr && (bus_addr == CTRL_OFF);
  assign wr_rsten     = bus_wr && (bus_addr == RSTEN_OFF);
  assign unused_wdata = &{1'b0, bus_wdata[DATA_W-1:CFG_W]};

  wdt_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr      (wr_ctrl),
    .wdata   (bus_wdata[CFG_W-1:0]),
    .cfg     (cfg_q),
    .written (written),
    .armed   (armed),
    .load    (load)
  );

  wdt_tick #(.PRESC_DIV(PRESC_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (armed),
    .restart (load),
    .presc   (cfg_q.presc),
    .tick    (tick)
  );

  wdt_down u_down (
    .clk    (clk),
    .rst_n  (rst_ni),
    .load   (load),
    .reload (written ? cfg_q.reload : bus_wdata[RLD_W-1:0]),
    .tick   (tick),
    .expire (expire)
  );

  wdt_rsten #(.W(RSTEN_W)) u_rsten (
    .clk   (clk),
    .rst_n (rst_ni),
    .wr    (wr_rsten),
    .wdata (bus_wdata[RSTEN_W-1:0]),
    .en    (rsten_q)
  );

  always_comb begin
    irq_d = irq_q;
    if (load)        irq_d = 1'b0;
    else if (expire) irq_d = 1'b1;
    rreq_d = expire && rsten_q[0] && rsten_q[1+WDT_IDX];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
    end
  end

  assign irq     = irq_q;
  assign rst_req = rreq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFF) begin
      bus_rdata[CFG_W-1:0] = cfg_q;
      bus_rdata[STAT_BIT]  = written;
    end else if (bus_addr == RSTEN_OFF) begin
      bus_rdata[RSTEN_W-1:0] = rsten_q;
    end
  end
endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk
  import wdt_pkg::*;
#(
  parameter int N_WDT   = 2,
  parameter int WDT_IDX = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             rst_req,
  input logic             load,
  input logic             written,
  input logic             armed,
  input logic [CFG_W-1:0] cfg,
  input logic [N_WDT:0]   rsten
);
  AST_KICK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !irq); // R6

  AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq); // R7

  AST_RST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rsten[0] && rsten[1+WDT_IDX])); // R8

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(written) |-> (written && $stable(cfg))); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!irq && !rst_req)); // R9
endmodule

bind wdt_top wdt_top_chk #(.N_WDT(N_WDT), .WDT_IDX(WDT_IDX)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .rst_req (rst_req),
  .load    (load),
  .written (written),
  .armed   (armed),
  .cfg     (cfg_q),
  .rsten   (rsten_q)
);

// File: tb/wdt_top_bench.sv
`timescale 1ns/1ps
module wdt_top_bench;
  localparam int          PDIV  = 8;
  localparam logic [11:0] A_CTL = 12'h000;
  localparam logic [11:0] A_RSE = 12'h120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int    cyc;
    bit    is_rst;
    string req;
  } ev_t;
  ev_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_top #(.PRESC_DIV(PDIV), .WDT_IDX(1)) u_wdt_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // Scoreboard driver side
  task automatic expect_ev(input int c, input bit r, input string req);
    ev_t ev;
    ev.cyc = c; ev.is_rst = r; ev.req = req;
    exp_q.push_back(ev);
  endtask

  task automatic observe(input bit r);
    ev_t ev;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL %s unexpected %s at cycle %0d (expected none)",
               r ? "R8" : "R6", r ? "rst_req" : "irq rise", cyc);
    end else begin
      ev = exp_q.pop_front();
      if (ev.cyc != cyc || ev.is_rst != r) begin
        n_fail++;
        $display("FAIL %s event kind=%0d cycle=%0d, expected kind=%0d cycle=%0d",
                 ev.req, r, cyc, ev.is_rst, ev.cyc);
      end
    end
  endtask

  // Scoreboard monitor side
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) irq_prev = 1'b0;
    else begin
      if (irq && !irq_prev) observe(1'b0);
      if (rst_req) observe(1'b1);
      irq_prev = irq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drain(input string req);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s %0d events missing, first expected at cycle %0d (actual none)",
               req, exp_q.size(), exp_q[0].cyc);
      exp_q.delete();
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output int e);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    e = cyc;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int e, k, x;
    fork
      begin
        do_reset();
        // R1 reset state
        chk("R1", {30'd0, irq, rst_req}, 32'd0);
        rd_chk(A_CTL, 32'h0, "R1");
        rd_chk(A_RSE, 32'h0, "R1");

        // R10 reset-enable register
        wr(A_RSE, 32'hFFFF_FFFF, x);
        rd_chk(A_RSE, 32'h7, "R10");
        wr(A_RSE, 32'h5, x);
        rd_chk(A_RSE, 32'h5, "R10");

        // R2 R4 R8 R7: arm, reload 3, no prescaler
        wr(A_CTL, 32'h0000_A003, e);
        expect_ev(e + 8, 1'b0, "R4");
        expect_ev(e + 8, 1'b1, "R8");
        expect_ev(e + 16, 1'b1, "R7");
        rd_chk(A_CTL, 32'h0001_A003, "R2");
        wait_until(e + 19);

        // R6 keepalive with unrelated data, R3 config unchanged
        wr(A_CTL, 32'hFFFF_0FFF, k);
        chk("R6", {31'd0, irq}, 32'd0);
        rd_chk(A_CTL, 32'h0001_A003, "R3");
        wr(A_RSE, 32'h4, x);           // instance bit only, master off
        expect_ev(k + 8, 1'b0, "R6");
        wait_until(k + 18);
        drain("R8");

        // R8: master on, other watchdog's bit only
        wr(A_CTL, 32'h0, k);
        wr(A_RSE, 32'h3, x);
        expect_ev(k + 8, 1'b0, "R6");
        wait_until(k + 18);
        wr(A_RSE, 32'h5, x);           // gating on again, irq stays sticky
        expect_ev(k + 24, 1'b1, "R8");
        expect_ev(k + 32, 1'b1, "R7");
        wait_until(k + 33);
        drain("R7");
        chk("R7", {31'd0, irq}, 32'd1);

        // R5 prescaled, reload 1
        do_reset();
        rd_chk(A_CTL, 32'h0, "R1");
        wr(A_RSE, 32'h5, x);
        wr(A_CTL, 32'h0000_B001, e);
        expect_ev(e + 4 * PDIV, 1'b0, "R5");
        expect_ev(e + 4 * PDIV, 1'b1, "R5");
        expect_ev(e + 8 * PDIV, 1'b1, "R7");
        rd_chk(A_CTL, 32'h0001_B001, "R2");
        wait_until(e + 8 * PDIV + 6);
        drain("R5");

        // R9 locked disarmed
        do_reset();
        wr(A_CTL, 32'h0000_8005, x);
        rd_chk(A_CTL, 32'h0001_8005, "R9");
        wr(A_RSE, 32'h5, x);
        wr(A_CTL, 32'h1234_5678, x);
        repeat (60) @(negedge clk);
        wr(A_CTL, 32'h0000_A001, x);
        rd_chk(A_CTL, 32'h0001_8005, "R3");
        repeat (60) @(negedge clk);
        drain("R9");
        chk("R9", {30'd0, irq, rst_req}, 32'd0);

        // R4 boundary: reload 0
        do_reset();
        wr(A_RSE, 32'h5, x);
        wr(A_CTL, 32'h0000_A000, e);
        expect_ev(e + 2, 1'b0, "R4");
        expect_ev(e + 2, 1'b1, "R8");
        expect_ev(e + 4, 1'b1, "R7");
        expect_ev(e + 6, 1'b1, "R7");
        wait_until(e + 6);
        do_reset();
        drain("R4");

        // R4 boundary: reload 4095
        wr(A_RSE, 32'h5, x);
        wr(A_CTL, 32'h0000_AFFF, e);
        expect_ev(e + 8192, 1'b0, "R4");
        expect_ev(e + 8192, 1'b1, "R8");
        wait_until(e + 8194);
        drain("R4");
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule